// File: doc/BRIEF.md
# Timer Frame Register Access Gate

This block is the register-access front end of one memory-mapped timer frame. It takes 32-bit read and write requests and decides for each whether the addressed register may be seen. The frame holds the physical count, the virtual count, the counter frequency, the virtual offset, a user-level access register, and two timer channels. Channel 0 is the physical timer and channel 1 is the virtual timer. Each channel has four word registers: compare low, compare high, timer value and control.

Every request carries a view flag. The primary view is gated only by a 6-bit frame permission register. The user-level view is further restricted by the enable bits in the user-level access register. The counter, the offset and the timer channels live outside the block and are reached through plain value inputs and a write strobe per channel. A request that is blocked, read-only or unmapped still completes: a read returns zero, a write has no effect, and no error is signalled.

Top module: `tfg_frame_gate`

## Requirements
- R1: Out of reset the frame permission register reads as 0. The user-level access register reads as 0x303 in the primary view, and no response is pending.
- R2: A write to the frame permission port keeps only bits [5:0] of the data. The bit meanings are: bit0 read physical count, bit1 read virtual count, bit2 read frequency, bit3 read virtual offset, bit4 access the virtual timer, bit5 access the physical timer.
- R3: The physical count (word offsets 0x00 and 0x04) is readable when permission bit0 is set. In the user view, user bit0 must also be set.
- R4: The frequency (offset 0x10) is readable when permission bit2 is set. In the user view, user bit0 or user bit1 must also be set.
- R5: The virtual offset (offsets 0x18 and 0x1C) is readable only when permission bit3 is set, and never through the user view.
- R6: Physical timer registers (offsets 0x20–0x2C) need permission bit5 and, in the user view, user bit9. Virtual timer registers (offsets 0x30–0x3C) need permission bit4 and, in the user view, user bit8. An allowed write raises exactly that channel's strobe for one cycle, with the register index (offset bits [3:2]) and the data.
- R7: Writes to the physical count, virtual count, frequency and virtual offset raise no strobe and change nothing.
- R8: Offsets at 0x40 and above read as zero and ignore writes.
- R9: The virtual count (offsets 0x08 and 0x0C) equals the physical count minus the virtual offset. It is readable with permission bit1 and, in the user view, user bit1.
- R10: The user-level access register (offset 0x14) holds bits 0, 1, 8 and 9, and all its other bits read as zero. It is read and written only in the primary view. In the user view it reads as zero and ignores writes.
- R11: Every request gets a response one cycle later. A blocked read responds with data zero.
- R12: 64-bit values are little-endian: the low word is at the lower offset and the high word at the offset 4 above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_user_view_i | input | 1 | Request comes through the user-level view |
| req_addr_i | input | 12 | Byte offset in the frame |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, zero when blocked |
| perm_wr_i | input | 1 | Write strobe for the frame permission register |
| perm_wdata_i | input | 32 | Frame permission write data |
| perm_o | output | 6 | Current frame permission bits |
| phys_cnt_i | input | 64 | Physical counter value |
| virt_off_i | input | 64 | Virtual offset value |
| cnt_freq_i | input | 32 | Counter frequency |
| chan_rdata_i | input | 256 | Channel registers, channel c register r at bits [(4c+r)*32 +: 32] |
| chan_wr_o | output | 2 | Per-channel write strobe |
| chan_widx_o | output | 2 | Register index of the write |
| chan_wdata_o | output | 32 | Write data to the channel |

## Verification
The checker tests several properties on every cycle:
- a response follows every request after exactly one cycle;
- at most one channel strobe is high, and only during a write request;
- a physical or virtual channel strobe only occurs while its permission bit is set;
- a permission write keeps exactly the low six bits;
- unmapped reads and user-view reads of the offset return zero.

The full gating matrix is shown only by the bench's sweep. That matrix covers the two permission layers, the view, the exact data on each offset, read-only writes, and the user register's view restriction.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
  localparam int DATA_W   = 32;
  localparam int PERM_W   = 6;
  localparam int NUM_CH   = 2;
  localparam int CH_REGS  = 4;
  localparam int CH_PHYS  = 0;
  localparam int CH_BASE  = 8;   // first channel word
  localparam int MAP_WORDS = CH_BASE + NUM_CH * CH_REGS;

  // frame permission bit positions
  localparam int P_PCT  = 0;
  localparam int P_VCT  = 1;
  localparam int P_FRQ  = 2;
  localparam int P_VOFF = 3;
  localparam int P_VT   = 4;
  localparam int P_PT   = 5;

  typedef struct packed {
    logic pten;   // word bit 9
    logic vten;   // word bit 8
    logic vcten;  // word bit 1
    logic pcten;  // word bit 0
  } user_acc_t;

  typedef enum logic [2:0] {
    RG_NONE, RG_PCT, RG_VCT, RG_FRQ, RG_UACR, RG_VOFF, RG_CHAN
  } region_e;
endpackage

// File: rtl/tfg_regs.sv
module tfg_regs
  import tfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              perm_wr_i,
  input  logic [DATA_W-1:0] perm_wdata_i,
  input  logic              uacr_wr_i,
  input  logic [DATA_W-1:0] uacr_wdata_i,
  output logic [PERM_W-1:0] perm_o,
  output user_acc_t         user_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perm_o <= '0;
      user_o <= '{pten: 1'b1, vten: 1'b1, vcten: 1'b1, pcten: 1'b1};
    end else begin
      if (perm_wr_i) perm_o <= perm_wdata_i[PERM_W-1:0];
      if (uacr_wr_i) begin
        user_o.pten  <= uacr_wdata_i[9];
        user_o.vten  <= uacr_wdata_i[8];
        user_o.vcten <= uacr_wdata_i[1];
        user_o.pcten <= uacr_wdata_i[0];
      end
    end
  end
endmodule

// File: rtl/tfg_decode.sv
module tfg_decode
  import tfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int WORD_W = ADDR_W - 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              user_view_i,
  input  logic [PERM_W-1:0] perm_i,
  input  user_acc_t         user_i,
  output region_e           region_o,
  output logic              hi_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [1:0]        ridx_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] ch_word;
  logic [NUM_CH-1:0] ch_ok;
  logic              pv;

  assign word    = addr_i[ADDR_W-1:2];
  assign ch_word = word - WORD_W'(CH_BASE);
  assign pv      = !user_view_i;
  assign hi_o    = word[0];
  assign ridx_o  = word[1:0];
  assign ch_o    = CH_W'(ch_word >> 2);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c == CH_PHYS) begin : g_phys
      assign ch_ok[c] = perm_i[P_PT] && (pv || user_i.pten);
    end else begin : g_virt
      assign ch_ok[c] = perm_i[P_VT] && (pv || user_i.vten);
    end
  end

  always_comb begin
    region_o = RG_NONE;
    if (word >= WORD_W'(CH_BASE) && word < WORD_W'(MAP_WORDS)) region_o = RG_CHAN;
    else if (word < WORD_W'(CH_BASE)) begin
      unique case (word[2:1])
        2'd0: region_o = RG_PCT;
        2'd1: region_o = RG_VCT;
        2'd2: region_o = word[0] ? RG_UACR : RG_FRQ;
        default: region_o = RG_VOFF;
      endcase
    end
  end

  always_comb begin
    rd_ok_o = 1'b0;
    wr_ok_o = 1'b0;
    unique case (region_o)
      RG_PCT:  rd_ok_o = perm_i[P_PCT] && (pv || user_i.pcten);
      RG_VCT:  rd_ok_o = perm_i[P_VCT] && (pv || user_i.vcten);
      RG_FRQ:  rd_ok_o = perm_i[P_FRQ] && (pv || user_i.pcten || user_i.vcten);
      RG_VOFF: rd_ok_o = perm_i[P_VOFF] && pv;
      RG_UACR: begin rd_ok_o = pv; wr_ok_o = pv; end
      RG_CHAN: begin
        rd_ok_o = ch_ok[ch_o];
        wr_ok_o = ch_ok[ch_o];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tfg_rsp.sv
module tfg_rsp
  import tfg_pkg::*;
#(
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  input  logic                             req_write_i,
  input  region_e                          region_i,
  input  logic                             hi_i,
  input  logic [CH_W-1:0]                  ch_i,
  input  logic [1:0]                       ridx_i,
  input  logic                             rd_ok_i,
  input  user_acc_t                        user_i,
  input  logic [63:0]                      phys_cnt_i,
  input  logic [63:0]                      virt_off_i,
  input  logic [DATA_W-1:0]                cnt_freq_i,
  input  logic [NUM_CH*CH_REGS*DATA_W-1:0] chan_rdata_i,
  output logic                             rsp_valid_o,
  output logic [DATA_W-1:0]                rsp_rdata_o
);
  logic [63:0]       vcnt;
  logic [DATA_W-1:0] mux;
  logic [DATA_W-1:0] uacr_word;
  logic [DATA_W-1:0] chan_word;

  assign vcnt      = phys_cnt_i - virt_off_i;
  assign uacr_word = {22'd0, user_i.pten, user_i.vten, 6'd0, user_i.vcten, user_i.pcten};
  assign chan_word = chan_rdata_i[(int'(ch_i) * CH_REGS + int'(ridx_i)) * DATA_W +: DATA_W];

  always_comb begin
    unique case (region_i)
      RG_PCT:  mux = hi_i ? phys_cnt_i[63:32] : phys_cnt_i[31:0];
      RG_VCT:  mux = hi_i ? vcnt[63:32] : vcnt[31:0];
      RG_FRQ:  mux = cnt_freq_i;
      RG_UACR: mux = uacr_word;
      RG_VOFF: mux = hi_i ? virt_off_i[63:32] : virt_off_i[31:0];
      RG_CHAN: mux = chan_word;
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (req_valid_i && !req_write_i && rd_ok_i) ? mux : '0;
    end
  end
endmodule

// File: rtl/tfg_frame_gate.sv
module tfg_frame_gate
  import tfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  input  logic                             req_write_i,
  input  logic                             req_user_view_i,
  input  logic [ADDR_W-1:0]                req_addr_i,
  input  logic [DATA_W-1:0]                req_wdata_i,
  output logic                             rsp_valid_o,
  output logic [DATA_W-1:0]                rsp_rdata_o,
  input  logic                             perm_wr_i,
  input  logic [DATA_W-1:0]                perm_wdata_i,
  output logic [PERM_W-1:0]                perm_o,
  input  logic [63:0]                      phys_cnt_i,
  input  logic [63:0]                      virt_off_i,
  input  logic [DATA_W-1:0]                cnt_freq_i,
  input  logic [NUM_CH*CH_REGS*DATA_W-1:0] chan_rdata_i,
  output logic [NUM_CH-1:0]                chan_wr_o,
  output logic [1:0]                       chan_widx_o,
  output logic [DATA_W-1:0]                chan_wdata_o
);
  user_acc_t       user_q;
  region_e         region;
  logic            hi;
  logic [CH_W-1:0] ch;
  logic [1:0]      ridx;
  logic            rd_ok;
  logic            wr_ok;
  logic            wr_go;

  assign wr_go = req_valid_i && req_write_i && wr_ok;

  tfg_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .perm_wr_i    (perm_wr_i),
    .perm_wdata_i (perm_wdata_i),
    .uacr_wr_i    (wr_go && region == RG_UACR),
    .uacr_wdata_i (req_wdata_i),
    .perm_o       (perm_o),
    .user_o       (user_q)
  );

  tfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i      (req_addr_i),
    .user_view_i (req_user_view_i),
    .perm_i      (perm_o),
    .user_i      (user_q),
    .region_o    (region),
    .hi_o        (hi),
    .ch_o        (ch),
    .ridx_o      (ridx),
    .rd_ok_o     (rd_ok),
    .wr_ok_o     (wr_ok)
  );

  tfg_rsp u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .region_i     (region),
    .hi_i         (hi),
    .ch_i         (ch),
    .ridx_i       (ridx),
    .rd_ok_i      (rd_ok),
    .user_i       (user_q),
    .phys_cnt_i   (phys_cnt_i),
    .virt_off_i   (virt_off_i),
    .cnt_freq_i   (cnt_freq_i),
    .chan_rdata_i (chan_rdata_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
    assign chan_wr_o[c] = wr_go && region == RG_CHAN && ch == CH_W'(c);
  end
  assign chan_widx_o  = ridx;
  assign chan_wdata_o = req_wdata_i;
endmodule

// File: rtl/tfg_frame_gate_chk.sv
module tfg_frame_gate_chk
  import tfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_write_i,
  input logic                req_user_view_i,
  input logic [ADDR_W-1:0]   req_addr_i,
  input logic                rsp_valid_o,
  input logic [DATA_W-1:0]   rsp_rdata_o,
  input logic                perm_wr_i,
  input logic [DATA_W-1:0]   perm_wdata_i,
  input logic [PERM_W-1:0]   perm_o,
  input logic [NUM_CH-1:0]   chan_wr_o
);
  logic rd_req;
  logic voff_addr;
  logic unmapped;
  assign rd_req    = req_valid_i && !req_write_i;
  assign voff_addr = req_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(6) ||
                     req_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(7);
  assign unmapped  = req_addr_i[ADDR_W-1:2] >= (ADDR_W-2)'(MAP_WORDS);

  p_rsp_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_rsp_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_wr_o));
  p_strobe_needs_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_wr_o) |-> (req_valid_i && req_write_i));
  p_phys_strobe_perm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_wr_o[CH_PHYS] |-> perm_o[P_PT]);
  p_virt_strobe_perm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_wr_o[1] |-> perm_o[P_VT]);
  p_perm_low_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_wr_i |=> perm_o == $past(perm_wdata_i[PERM_W-1:0]));
  p_voff_user_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_user_view_i && voff_addr) |=> rsp_rdata_o == '0);
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && unmapped) |=> rsp_rdata_o == '0);
endmodule

bind tfg_frame_gate tfg_frame_gate_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tfg_frame_gate_bench.sv
module tfg_frame_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic         req_valid = 0, req_write = 0, req_user = 0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         perm_wr = 0;
  logic [31:0]  perm_wdata = '0;
  logic [5:0]   perm;
  logic [63:0]  pcnt = 64'h1111_2222_3333_4444;
  logic [63:0]  voff = 64'h0000_0100_0000_0200;
  logic [31:0]  freq = 32'h0262_5A00;
  logic [255:0] chan_rd;
  logic [1:0]   chan_wr;
  logic [1:0]   chan_widx;
  logic [31:0]  chan_wdata;

  int checks = 0, fails = 0;
  bit done = 0;

  for (genvar k = 0; k < 8; k++) begin : g_crd
    assign chan_rd[k*32 +: 32] = 32'hA500_0000 | 32'(k);
  end

  tfg_frame_gate u_tfg_frame_gate (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_user_view_i(req_user),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .perm_wr_i(perm_wr), .perm_wdata_i(perm_wdata), .perm_o(perm),
    .phys_cnt_i(pcnt), .virt_off_i(voff), .cnt_freq_i(freq),
    .chan_rdata_i(chan_rd), .chan_wr_o(chan_wr), .chan_widx_o(chan_widx),
    .chan_wdata_o(chan_wdata)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // u: bit0 pcten, bit1 vcten, bit2 vten, bit3 pten
  function automatic logic [31:0] exp_read(int p, int u, bit el, int w);
    logic [63:0] vc;
    bit pv;
    vc = pcnt - voff;
    pv = !el;
    case (w)
      0, 1:   return (p[0] && (pv || u[0])) ? (w == 1 ? pcnt[63:32] : pcnt[31:0]) : 32'd0;
      2, 3:   return (p[1] && (pv || u[1])) ? (w == 3 ? vc[63:32] : vc[31:0]) : 32'd0;
      4:      return (p[2] && (pv || u[0] || u[1])) ? freq : 32'd0;
      5:      return pv ? {22'd0, u[3], u[2], 6'd0, u[1], u[0]} : 32'd0;
      6, 7:   return (p[3] && pv) ? (w == 7 ? voff[63:32] : voff[31:0]) : 32'd0;
      8, 9, 10, 11:   return (p[5] && (pv || u[3])) ? (32'hA500_0000 | 32'(w - 8)) : 32'd0;
      12, 13, 14, 15: return (p[4] && (pv || u[2])) ? (32'hA500_0000 | 32'(w - 8)) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [1:0] exp_strobe(int p, int u, bit el, int w);
    if (w >= 8 && w < 12 && p[5] && (!el || u[3])) return 2'b01;
    if (w >= 12 && w < 16 && p[4] && (!el || u[2])) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string tag_of(int w);
    case (w)
      0, 1: return "R3/R12";
      2, 3: return "R9";
      4: return "R4";
      5: return "R10";
      6, 7: return "R5";
      default: return (w < 16) ? "R6" : "R8";
    endcase
  endfunction

  task automatic do_read(bit el, int w, output logic [31:0] data, output logic vld);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_user = el; req_addr = 12'(w * 4);
    @(posedge clk); #1;
    data = rsp_rdata; vld = rsp_valid;
    req_valid = 0;
  endtask

  task automatic do_write(bit el, int w, logic [31:0] d, output logic [1:0] stb,
                          output logic [1:0] idx, output logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_user = el; req_addr = 12'(w * 4); req_wdata = d;
    #1;
    stb = chan_wr; idx = chan_widx; wd = chan_wdata;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic set_perm(logic [31:0] d);
    @(negedge clk);
    perm_wr = 1; perm_wdata = d;
    @(negedge clk);
    perm_wr = 0;
  endtask

  initial begin
    #(4ns * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] wd;
    logic [1:0] stb, idx;
    logic v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 perm", 64'(perm), 64'd0);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    @(negedge clk); rst_n = 1;
    do_read(0, 5, d, v);
    check("R1 user reg", 64'(d), 64'h303);
    check("R11 valid", 64'(v), 64'd1);
    // R2 low six bits kept
    set_perm(32'hFFFF_FFC5);
    check("R2 perm", 64'(perm), 64'h05);
    // R10 user view write ignored, primary write masked
    do_write(1, 5, 32'h0, stb, idx, wd);
    do_read(0, 5, d, v);
    check("R10 user-view write ignored", 64'(d), 64'h303);
    do_write(0, 5, 32'h0, stb, idx, wd);
    do_read(0, 5, d, v);
    check("R10 cleared", 64'(d), 64'h0);
    do_write(0, 5, 32'hFFFF_FFFF, stb, idx, wd);
    do_read(0, 5, d, v);
    check("R10 mask", 64'(d), 64'h303);
    // R11 blocked read still responds with zero
    set_perm(32'h0);
    do_read(0, 0, d, v);
    check("R11 blocked valid", 64'(v), 64'd1);
    check("R11 blocked data", 64'(d), 64'd0);

    // exhaustive sweep
    for (int p = 0; p < 64; p++) begin
      set_perm(32'(p));
      for (int u = 0; u < 16; u++) begin
        do_write(0, 5, {22'd0, u[3], u[2], 6'd0, u[1], u[0]}, stb, idx, wd);
        for (int el = 0; el < 2; el++) begin
          for (int wi = 0; wi < 18; wi++) begin
            automatic int w = (wi == 16) ? 16 : (wi == 17) ? 1023 : wi;
            do_read(el[0], w, d, v);
            check(tag_of(w), 64'(d), 64'(exp_read(p, u, el[0], w)));
            if (w != 5) begin
              do_write(el[0], w, 32'h5A00_0000 | 32'(w), stb, idx, wd);
              check((w < 8) ? "R7 strobe" : (w < 16) ? "R6 strobe" : "R8 strobe",
                    64'(stb), 64'(exp_strobe(p, u, el[0], w)));
              if (stb != 2'b00) begin
                check("R6 index", 64'(idx), 64'(w % 4));
                check("R6 data", 64'(wd), 64'(32'h5A00_0000 | 32'(w)));
              end
            end
          end
        end
      end
    end

    // R7: read-only writes left the permission and user register intact
    do_read(0, 5, d, v);
    check("R7 user reg after sweep", 64'(d), 64'h303);
    check("R7 perm after sweep", 64'(perm), 64'd63);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule